// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block chooses which of four reference clock inputs drives a downstream frequency synthesizer. It keeps a sticky health flag for each input (1 healthy, 0 failed) and, in automatic mode, moves to another input when the current one fails. Failure detection happens elsewhere. Each input reports a single-cycle failure pulse that is already synchronized into the control clock domain. A qualifier mask can exclude inputs. A global enable decides whether that mask applies at all.

Flags can be cleared in two ways. A falling edge on the alarm-clear pin restores every flag and returns the selection to the primary input. A register write restores only the flags whose bits are written as 0, and it leaves the selection where it is. If no input is both healthy and qualified, the block drops its lock indication. It stays unlocked until master reset, even if inputs recover in the meantime.

All ports are plain control and status signals. There is no streaming data path, so no port uses a valid/ready handshake. Every input is sampled on each rising clock edge, and every output comes from a register.

Top module: `refclk_failover`

## Requirements
- R1: While `mrst` is high on a rising edge, the next state has `sel_code` equal to `mode[1:0]`, all `clk_ok` bits at 1 and `lock` at 1.
- R2: A pulse on `fail_evt[i]` clears `clk_ok[i]` on that edge if input i is effectively qualified. With `qual_en`=1 and `qual_mask[i]`=0, the pulse is ignored.
- R3: With `qual_en`=0, all four inputs are treated as qualified, whatever `qual_mask` holds.
- R4: A cleared `clk_ok` bit stays 0 until a pin clear, a register clear of that bit, or master reset.
- R5: With `mode[2]`=1 (automatic), a failure of the selected input changes `sel_code` on the same edge that clears the flag. The new selection is the first input, in ascending circular order starting after the failed one, that is both healthy and qualified.
- R6: In automatic mode, if the selected input loses its effective qualification, the selection moves on the next edge, using the same search as R5.
- R7: When `alarm_clr_n` is sampled high and then low on two consecutive edges, the second edge sets all flags to 1 and sets `sel_code` to `mode[1:0]`. A rising edge on the pin has no effect.
- R8: A cycle with `wr_en`=1 sets to 1 each flag whose `wr_data` bit is 0. Bits written as 1 have no effect, and `sel_code` does not change.
- R9: With `mode[2]`=0 (manual), failures never change `sel_code`.
- R10: If no input is both healthy and effectively qualified after an edge, `lock` goes to 0 and `sel_code` holds. `lock` stays 0 until master reset, even after flags are cleared.
- R11: `sel_code` uses 00 for input 0, 01 for input 1, 10 for input 2 and 11 for input 3.
- R12: `stat_img` holds `sel_code` in bits 1:0 and `clk_ok[3:0]` in bits 6:3. Bits 2 and 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| mrst | input | 1 | Synchronous active-high master reset |
| fail_evt | input | 4 | Per-input failure pulse, one cycle wide, already synchronized |
| mode | input | 3 | Bits 1:0 give the primary input. Bit 2: 1 automatic, 0 manual |
| qual_mask | input | 4 | Per-input qualifier, 1 = eligible |
| qual_en | input | 1 | 1 applies `qual_mask`, 0 treats all inputs as qualified |
| alarm_clr_n | input | 1 | Clear-all pin, acts on a falling edge |
| wr_en | input | 1 | Strobe for a per-flag clear write |
| wr_data | input | 4 | Per-flag clear pattern, 0 restores that flag |
| sel_code | output | 2 | Code of the active input |
| clk_ok | output | 4 | Sticky health flags, 1 healthy |
| stat_img | output | 8 | Readable status image |
| lock | output | 1 | 0 once no usable input remained |

## Verification
Failover is tested with failure patterns that each separate a different wrong search:
- A single failure on input 0 shows the order is ascending.
- A failure on input 1 while input 2 is disqualified shows the search skips excluded inputs.
- A primary of 3 failing shows the search wraps to input 0.
- A failure when every other input is unusable shows the block latches no-lock instead of picking something.

Failure pulses on a masked input are sent twice, once with the qualifier enable set and once with it cleared, to show the enable matters. The two clear paths are both run from a failed-over state. That separates the clear that reverts the selection from the clear that does not.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int REF_N = 4;
  localparam int REF_SW = $clog2(REF_N);
  // status image layout: select code at the bottom, one spare bit, flags above
  localparam int STAT_FLAG_LSB = REF_SW + 1;
  localparam int STAT_W = STAT_FLAG_LSB + REF_N + 1;

  typedef struct packed {
    logic              auto_en;
    logic [REF_SW-1:0] primary;
  } ref_mode_t;
endpackage

// File: rtl/rf_flag_bank.sv
module rf_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic [N-1:0] fail_evt,
  input  logic [N-1:0] eff_qual,
  input  logic         pin_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags,
  output logic [N-1:0] flags_nxt,
  output logic         pin_fall
);
  logic         pin_q;
  logic [N-1:0] reg_clr;
  logic [N-1:0] hit;

  always_ff @(posedge clk) begin
    if (mrst) pin_q <= 1'b1;
    else      pin_q <= pin_n;
  end

  assign pin_fall = pin_q & ~pin_n;
  assign reg_clr  = wr_en ? ~wr_data : '0;
  assign hit      = fail_evt & eff_qual;

  always_comb begin
    if (pin_fall) flags_nxt = '1;
    else          flags_nxt = (flags | reg_clr) & ~hit;
  end

  always_ff @(posedge clk) begin
    if (mrst) flags <= '1;
    else      flags <= flags_nxt;
  end

  // R7
  pin_clr_all_chk: assert property (@(posedge clk) disable iff (mrst)
    pin_fall |=> (&flags));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (mrst)
      (!flags[i] && !pin_fall && !(wr_en && !wr_data[i])) |=> !flags[i]);
    // R2
    flag_masked_chk: assert property (@(posedge clk) disable iff (mrst)
      (flags[i] && !eff_qual[i]) |=> flags[i]);
  end
endmodule

// File: rtl/rf_next_pick.sv
module rf_next_pick #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [SW-1:0] cur,
  input  logic [N-1:0]  usable,
  output logic [SW-1:0] nxt,
  output logic          found
);
  // Scan from the farthest candidate down to the nearest one, so the
  // nearest usable input in ascending circular order wins.
  always_comb begin
    nxt   = cur;
    found = 1'b0;
    for (int k = N - 1; k >= 1; k--) begin
      logic [SW-1:0] idx;
      idx = cur + SW'(k);
      if (usable[idx]) begin
        nxt   = idx;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_sel_ctrl.sv
module rf_sel_ctrl #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          auto_en,
  input  logic [SW-1:0] primary,
  input  logic          pin_fall,
  input  logic [N-1:0]  usable_nxt,
  output logic [SW-1:0] sel,
  output logic          nolock
);
  logic [SW-1:0] cand;
  logic          cand_ok;
  logic          move;

  rf_next_pick #(.N(N)) u_pick (
    .cur    (sel),
    .usable (usable_nxt),
    .nxt    (cand),
    .found  (cand_ok)
  );

  assign move = auto_en && !nolock && !usable_nxt[sel] && cand_ok;

  always_ff @(posedge clk) begin
    if (mrst)          sel <= primary;
    else if (pin_fall) sel <= primary;
    else if (move)     sel <= cand;
  end

  always_ff @(posedge clk) begin
    if (mrst) nolock <= 1'b0;
    else      nolock <= nolock | (usable_nxt == '0);
  end

  // R9
  sel_manual_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    (!auto_en && !pin_fall) |=> $stable(sel));
  // R10
  nolock_sticky_chk: assert property (@(posedge clk) disable iff (mrst)
    nolock |=> nolock);
  // R7
  pin_sel_primary_chk: assert property (@(posedge clk) disable iff (mrst)
    pin_fall |=> (sel == $past(primary)));
  // R8
  sel_keep_healthy_chk: assert property (@(posedge clk) disable iff (mrst)
    (usable_nxt[sel] && !pin_fall) |=> $stable(sel));
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refclk_pkg::*;
#(
  parameter int N_IN = REF_N,
  localparam int SW = $clog2(N_IN),
  localparam int FLAG_LSB = SW + 1,
  localparam int IMG_W = FLAG_LSB + N_IN + 1
) (
  input  logic            clk,
  input  logic            mrst,
  input  logic [N_IN-1:0] fail_evt,
  input  logic [SW:0]     mode,
  input  logic [N_IN-1:0] qual_mask,
  input  logic            qual_en,
  input  logic            alarm_clr_n,
  input  logic            wr_en,
  input  logic [N_IN-1:0] wr_data,
  output logic [SW-1:0]   sel_code,
  output logic [N_IN-1:0] clk_ok,
  output logic [IMG_W-1:0] stat_img,
  output logic            lock
);
  logic [N_IN-1:0] eff_qual;
  logic [N_IN-1:0] flags_nxt;
  logic            pin_fall;
  logic            nolock;
  logic            auto_en;
  logic [SW-1:0]   primary;

  assign auto_en  = mode[SW];
  assign primary  = mode[SW-1:0];
  assign eff_qual = qual_en ? qual_mask : '1;

  rf_flag_bank #(.N(N_IN)) u_flags (
    .clk       (clk),
    .mrst      (mrst),
    .fail_evt  (fail_evt),
    .eff_qual  (eff_qual),
    .pin_n     (alarm_clr_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flags     (clk_ok),
    .flags_nxt (flags_nxt),
    .pin_fall  (pin_fall)
  );

  rf_sel_ctrl #(.N(N_IN)) u_sel (
    .clk        (clk),
    .mrst       (mrst),
    .auto_en    (auto_en),
    .primary    (primary),
    .pin_fall   (pin_fall),
    .usable_nxt (flags_nxt & eff_qual),
    .sel        (sel_code),
    .nolock     (nolock)
  );

  assign lock = ~nolock;

  always_comb begin
    stat_img = '0;
    stat_img[SW-1:0] = sel_code;
    stat_img[FLAG_LSB +: N_IN] = clk_ok;
  end

  // R12
  img_layout_chk: assert property (@(posedge clk) disable iff (mrst)
    (stat_img[SW] == 1'b0) && (stat_img[IMG_W-1] == 1'b0));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    mrst |=> ((&clk_ok) && lock && (sel_code == $past(primary))));
endmodule

// File: tb/sim_refclk_failover.sv
module sim_refclk_failover;
  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic [3:0] fail_evt = '0;
  logic [2:0] mode = 3'b100;
  logic [3:0] qual_mask = 4'hF;
  logic       qual_en = 1'b1;
  logic       alarm_clr_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'hF;
  logic [1:0] sel_code;
  logic [3:0] clk_ok;
  logic [7:0] stat_img;
  logic       lock;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  refclk_failover u0 (
    .clk(clk), .mrst(mrst), .fail_evt(fail_evt), .mode(mode),
    .qual_mask(qual_mask), .qual_en(qual_en), .alarm_clr_n(alarm_clr_n),
    .wr_en(wr_en), .wr_data(wr_data), .sel_code(sel_code),
    .clk_ok(clk_ok), .stat_img(stat_img), .lock(lock)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compares every output against an expected state; the image is built from R12
  task automatic expect_all(string req, logic [1:0] s, logic [3:0] f, logic l);
    chk({req, " sel"}, sel_code, s);
    chk({req, " flags"}, clk_ok, f);
    chk({req, " lock"}, lock, l);
    chk({req, " R12 image"}, stat_img, {1'b0, f, 1'b0, s});
  endtask

  task automatic do_reset(logic [2:0] m);
    mode = m;
    mrst = 1'b1;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic pulse_fail(logic [3:0] m);
    fail_evt = m;
    @(negedge clk);
    fail_evt = '0;
  endtask

  task automatic reg_write(logic [3:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 4'hF;
  endtask

  task automatic t_reset;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b100);
    expect_all("R1 reset primary0", 2'd0, 4'hF, 1'b1);
    do_reset(3'b110);
    expect_all("R1 R11 reset primary2", 2'd2, 4'hF, 1'b1);
  endtask

  task automatic t_chain;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b100);
    pulse_fail(4'b0001);
    expect_all("R5 fail0 to 1", 2'd1, 4'b1110, 1'b1);
    repeat (3) @(negedge clk);
    chk("R4 flag0 sticky", clk_ok, 4'b1110);
    qual_mask = 4'b1011;
    pulse_fail(4'b0010);
    expect_all("R5 skip disqualified 2", 2'd3, 4'b1100, 1'b1);
    pulse_fail(4'b1000);
    expect_all("R10 none usable", 2'd3, 4'b0100, 1'b0);
    reg_write(4'b1110);
    expect_all("R10 R8 lock held after clear", 2'd3, 4'b0101, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 lock still low", lock, 0);
    qual_mask = 4'hF;
    do_reset(3'b100);
    expect_all("R10 R1 reset relocks", 2'd0, 4'hF, 1'b1);
  endtask

  task automatic t_wrap;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b111);
    chk("R11 primary3 code", sel_code, 3);
    pulse_fail(4'b1000);
    expect_all("R5 wrap 3 to 0", 2'd0, 4'b0111, 1'b1);
  endtask

  task automatic t_reg_clear;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b100);
    pulse_fail(4'b0001);
    pulse_fail(4'b0100);
    expect_all("R4 two failures", 2'd1, 4'b1010, 1'b1);
    reg_write(4'b1111);
    expect_all("R8 ones ignored", 2'd1, 4'b1010, 1'b1);
    reg_write(4'b1110);
    expect_all("R8 clear bit0 keeps sel", 2'd1, 4'b1011, 1'b1);
  endtask

  task automatic t_pin_clear;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b101);
    pulse_fail(4'b0010);
    expect_all("R5 fail1 to 2", 2'd2, 4'b1101, 1'b1);
    alarm_clr_n = 1'b0;
    @(negedge clk);
    expect_all("R7 pin fall clears", 2'd1, 4'hF, 1'b1);
    pulse_fail(4'b0010);
    alarm_clr_n = 1'b1;
    @(negedge clk);
    expect_all("R7 rising edge no effect", 2'd2, 4'b1101, 1'b1);
  endtask

  task automatic t_manual;
    qual_mask = 4'hF; qual_en = 1'b1;
    do_reset(3'b010);
    pulse_fail(4'b0100);
    expect_all("R9 manual holds", 2'd2, 4'b1011, 1'b1);
    pulse_fail(4'b0001);
    expect_all("R9 manual holds again", 2'd2, 4'b1010, 1'b1);
  endtask

  task automatic t_qual;
    qual_mask = 4'b1101; qual_en = 1'b1;
    do_reset(3'b100);
    pulse_fail(4'b0010);
    expect_all("R2 masked fail ignored", 2'd0, 4'hF, 1'b1);
    qual_en = 1'b0;
    pulse_fail(4'b0010);
    expect_all("R3 mask bypassed", 2'd0, 4'b1101, 1'b1);
    qual_en = 1'b1;
    qual_mask = 4'b1110;
    @(negedge clk);
    chk("R6 disqualified selection moves", sel_code, 2);
    chk("R6 lock kept", lock, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_chain();
    t_wrap();
    t_reg_clear();
    t_pin_clear();
    t_manual();
    t_qual();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule